// File: doc/BRIEF.md
# Serial EEPROM Page Write Commit Engine

This block sits behind a two-wire serial slave front-end and turns a write command into a nonvolatile page update. The front-end hands it a start word address, then a stream of data bytes, then a Stop event. Bytes collect in a page-sized staging buffer. On Stop the whole staged page is copied into an on-chip byte array, and a busy flag is held for a fixed programming time.

Only the low page-offset bits of the internal address pointer advance as bytes arrive. A long or misaligned write therefore folds back onto the start of the same page and never reaches the next one. When the first data byte arrives, the staging buffer is filled with the page's current contents. Because of this, a short write rewrites every byte of the page and leaves the untouched bytes as they were.

The write-protect input is looked at only at the moment of Stop. A combinational read port lets the surrounding logic observe any array byte. The array is cleared at reset.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset `busy` is 0, `addr_ptr` is 0 and every array byte reads 0.
- R2: A command with one data byte, followed by Stop with `wp` low, stores the byte at the start address and leaves `addr_ptr` at start address + 1.
- R3: Consecutive data bytes go to consecutive addresses. After each byte, the low PAGE_W bits of `addr_ptr` increase by one.
- R4: The upper ADDR_W-PAGE_W bits of `addr_ptr` never change while bytes arrive. With 64-byte pages, a write that starts at page offset 62 and carries 4 bytes fills offsets 62, 63, 0 and 1 of the same page, and the following page stays untouched.
- R5: If more than 64 bytes arrive before Stop, the later bytes replace the earlier bytes at the same page offsets.
- R6: A write of fewer than 64 bytes leaves every other byte of that page at its previous value.
- R7: If `wp` is 1 in the Stop cycle, nothing is stored and `busy` stays 0. A new command is accepted in the very next cycle.
- R8: `wp` counts only in the Stop cycle. A high `wp` during the data bytes does not block the write, and raising `wp` after Stop does not stop a commit already under way.
- R9: `busy` rises in the cycle after Stop and stays high for exactly WRITE_CYCLES clock cycles.
- R10: While `busy` is 1, `cmd_start`, `data_valid` and `stop` are ignored: `addr_ptr` holds and the array is not changed by them.
- R11: Stop with no data byte after the address starts no commit, and `addr_ptr` keeps the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: a write command begins at `start_addr` |
| start_addr | input | ADDR_W | Word address of the first byte |
| data_valid | input | 1 | One-cycle pulse: `data_byte` holds a received byte |
| data_byte | input | 8 | Received data byte |
| stop | input | 1 | One-cycle pulse: Stop condition seen on the bus |
| wp | input | 1 | Write protect, examined only at Stop |
| busy | output | 1 | Internal programming cycle under way |
| addr_ptr | output | ADDR_W | Current internal address pointer |
| rd_addr | input | ADDR_W | Array observation address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |

## Verification
The hardest situation to reach from the ports is the page-buffer roll-over. Reaching it takes more than a full page of bytes in one command, and the pointer must also cross the page-offset boundary without touching the page index. The bench drives a 66-byte burst, so the first two staged bytes are overwritten before Stop. It also drives a separate 4-byte burst that starts two bytes short of a page end. It then reads both the wrapped page and the untouched next page through the observation port. Partial-page refresh is reached by writing one byte into a page already filled by an earlier command.

// File: rtl/epc_pkg.sv
// Package: types shared by the page commit engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package epc_pkg;

    // Controller phase: waiting, collecting bytes, committing the page
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_COMMIT = 2'd2
    } epc_state_t;

endpackage

// File: rtl/epc_array.sv
// Module: byte array that stands in for the nonvolatile cells.
// One write port used by the commit sequence, one random read port for
// observation, and a whole-page parallel view used to preload the buffer.
// Assumes ADDR_W > PAGE_W. Cleared to zero by synchronous reset.
module epc_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [7:0]                           wr_data,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [7:0]                           rd_data,
    input  logic [ADDR_W-PAGE_W-1:0]             page_sel,
    output logic [(1<<PAGE_W)-1:0][7:0]          page_q
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] cells [DEPTH];

    // Clear on reset, otherwise take one committed byte per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'h00;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Observation read
    assign rd_data = cells[rd_addr];

    // Parallel view of the selected page, one lane per byte offset
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page_lane
        assign page_q[g] = cells[{page_sel, PAGE_W'(g)}];
    end

endmodule

// File: rtl/epc_page_buffer.sv
// Module: page-sized staging buffer.
// A preload copies a whole page in one cycle. A byte write in the same
// cycle wins over the preload at its own offset. Assumes the controller
// never preloads and reads in the same cycle.
module epc_page_buffer #(
    parameter int PAGE_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            preload,
    input  logic [(1<<PAGE_W)-1:0][7:0]     preload_data,
    input  logic                            wr_en,
    input  logic [PAGE_W-1:0]               wr_idx,
    input  logic [7:0]                      wr_data,
    input  logic [PAGE_W-1:0]               rd_idx,
    output logic [7:0]                      rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [PAGE_BYTES-1:0][7:0] slots;

    // Load the page image, then let the incoming byte override its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            if (preload) begin
                slots <= preload_data;
            end
            if (wr_en) begin
                slots[wr_idx] <= wr_data;
            end
        end
    end

    // Byte selected by the commit sequence
    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/epc_ctrl.sv
// Module: command sequencer and address pointer.
// Tracks the command phase, steps only the page-offset bits of the
// pointer, decides at Stop whether to commit, and times the commit.
// Assumes WRITE_CYCLES >= 2**PAGE_W so the copy fits in the busy window.
// Input pulses are one cycle wide. Within one cycle stop beats cmd_start,
// and cmd_start beats data_valid.
module epc_ctrl
    import epc_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_start,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic                      data_valid,
    input  logic                      stop,
    input  logic                      wp,
    output logic [ADDR_W-1:0]         ptr,
    output logic                      busy,
    output logic                      recv_open,
    output logic                      got_data,
    output logic                      buf_preload,
    output logic                      buf_wr,
    output logic [PAGE_W-1:0]         buf_idx,
    output logic [ADDR_W-PAGE_W-1:0]  view_page,
    output logic                      arr_wr,
    output logic [ADDR_W-1:0]         arr_addr,
    output logic [PAGE_W-1:0]         copy_idx
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PIDX_W     = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

    epc_state_t          state;
    logic [PIDX_W-1:0]   commit_page;
    logic [CNT_W-1:0]    cnt;
    logic                take_byte;

    // A byte is taken only while collecting and with no higher-priority event
    assign take_byte   = (state == ST_RECV) && data_valid && !stop && !cmd_start;
    assign buf_preload = take_byte && !got_data;
    assign buf_wr      = take_byte;
    assign buf_idx     = ptr[PAGE_W-1:0];
    assign view_page   = ptr[ADDR_W-1:PAGE_W];
    assign recv_open   = (state == ST_RECV);
    assign busy        = (state == ST_COMMIT);
    assign copy_idx    = cnt[PAGE_W-1:0];
    assign arr_wr      = (state == ST_COMMIT) && (cnt < CNT_W'(PAGE_BYTES));
    assign arr_addr    = {commit_page, cnt[PAGE_W-1:0]};

    // Phase, pointer and commit timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ptr         <= '0;
            got_data    <= 1'b0;
            commit_page <= '0;
            cnt         <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        state    <= ST_RECV;
                        ptr      <= start_addr;
                        got_data <= 1'b0;
                    end
                end
                ST_RECV: begin
                    if (stop) begin
                        if (got_data && !wp) begin
                            state       <= ST_COMMIT;
                            commit_page <= ptr[ADDR_W-1:PAGE_W];
                            cnt         <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                        got_data <= 1'b0;
                    end else if (cmd_start) begin
                        ptr      <= start_addr;
                        got_data <= 1'b0;
                    end else if (data_valid) begin
                        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                        got_data        <= 1'b1;
                    end
                end
                ST_COMMIT: begin
                    if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_page_commit.sv
// Module: top of the page commit engine.
// Connects the sequencer, the staging buffer and the cell array.
// Assumes the front-end delivers cmd_start, data_valid and stop as
// single-cycle pulses already synchronised to clk.
module eeprom_page_commit #(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               data_valid,
    input  logic [7:0]         data_byte,
    input  logic               stop,
    input  logic               wp,
    output logic               busy,
    output logic [ADDR_W-1:0]  addr_ptr,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PIDX_W     = ADDR_W - PAGE_W;

    logic                         recv_open;
    logic                         got_data;
    logic                         buf_preload;
    logic                         buf_wr;
    logic [PAGE_W-1:0]            buf_idx;
    logic [PIDX_W-1:0]            view_page;
    logic                         arr_wr;
    logic [ADDR_W-1:0]            arr_addr;
    logic [PAGE_W-1:0]            copy_idx;
    logic [7:0]                   copy_byte;
    logic [PAGE_BYTES-1:0][7:0]   page_image;

    epc_ctrl #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .start_addr  (start_addr),
        .data_valid  (data_valid),
        .stop        (stop),
        .wp          (wp),
        .ptr         (addr_ptr),
        .busy        (busy),
        .recv_open   (recv_open),
        .got_data    (got_data),
        .buf_preload (buf_preload),
        .buf_wr      (buf_wr),
        .buf_idx     (buf_idx),
        .view_page   (view_page),
        .arr_wr      (arr_wr),
        .arr_addr    (arr_addr),
        .copy_idx    (copy_idx)
    );

    epc_page_buffer #(
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .preload      (buf_preload),
        .preload_data (page_image),
        .wr_en        (buf_wr),
        .wr_idx       (buf_idx),
        .wr_data      (data_byte),
        .rd_idx       (copy_idx),
        .rd_data      (copy_byte)
    );

    epc_array #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (arr_wr),
        .wr_addr  (arr_addr),
        .wr_data  (copy_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .page_sel (view_page),
        .page_q   (page_image)
    );

endmodule

// File: rtl/epc_checker.sv
// Module: protocol checker bound to the commit engine.
// Observes ports and the sequencer's phase outputs only. Keeps its own
// busy-length counter, so no long $past windows are needed.
module epc_checker #(
    parameter int ADDR_W       = 11,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              data_valid,
    input logic              stop,
    input logic              wp,
    input logic              busy,
    input logic [ADDR_W-1:0] addr_ptr,
    input logic              recv_open,
    input logic              got_data
);
    int unsigned busy_run;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        recv_open && stop && got_data && !wp |=> busy); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        recv_open && data_valid && !stop && !cmd_start |=>
        addr_ptr[PAGE_W-1:0] == PAGE_W'($past(addr_ptr[PAGE_W-1:0]) + 1'b1)); // R3
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        recv_open && data_valid && !stop && !cmd_start |=>
        addr_ptr[ADDR_W-1:PAGE_W] == $past(addr_ptr[ADDR_W-1:PAGE_W])); // R4
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        recv_open && stop && wp |=> !busy); // R7
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == WRITE_CYCLES); // R9
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_ptr)); // R10
    AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        recv_open && stop && !got_data |=> !busy); // R11

endmodule

bind eeprom_page_commit epc_checker #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (.*);

// File: tb/eeprom_page_commit_bench.sv
module eeprom_page_commit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int PW         = 6;
    localparam int WC         = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          data_valid = 1'b0;
    logic [7:0]    data_byte = '0;
    logic          stop = 1'b0;
    logic          wp = 1'b0;
    logic          busy;
    logic [AW-1:0] addr_ptr;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_commit #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) u_eeprom_page_commit (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .data_valid(data_valid), .data_byte(data_byte), .stop(stop), .wp(wp),
        .busy(busy), .addr_ptr(addr_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [AW-1:0] a);
        @(negedge clk); start_addr = a; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        data_byte = b; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
    endtask

    // Stop pulse; returns at the negedge just after the Stop edge
    task automatic send_stop();
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 10*WC) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic chk_mem(input string tag, input logic [AW-1:0] a, input logic [7:0] e);
        logic [7:0] d;
        peek(a, d);
        chk(tag, {24'h0, d}, {24'h0, e});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy after reset", {31'h0, busy}, 0);
        chk("R1 pointer after reset", {21'h0, addr_ptr}, 0);
        chk_mem("R1 array cleared", 11'h105, 8'h00);
        chk_mem("R1 array cleared", 11'h7FF, 8'h00);
    endtask

    task automatic t_byte_write();
        int n;
        send_cmd(11'h105); send_byte(8'hA5); send_stop();
        chk("R9 busy rises after stop", {31'h0, busy}, 1);
        wait_idle(n);
        chk("R9 busy length", n, WC);
        chk_mem("R2 byte stored", 11'h105, 8'hA5);
        chk_mem("R2 neighbour clear", 11'h106, 8'h00);
        chk("R2 pointer after byte", {21'h0, addr_ptr}, 32'h106);
    endtask

    task automatic t_page_write();
        int n;
        send_cmd(11'h200);
        for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
        send_stop(); wait_idle(n);
        for (int i = 0; i < 5; i++) chk_mem("R3 consecutive byte", 11'h200 + 11'(i), 8'h10 + 8'(i));
        chk("R3 pointer after burst", {21'h0, addr_ptr}, 32'h205);
    endtask

    task automatic t_wrap();
        int n;
        send_cmd(11'h27E);
        for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
        send_stop(); wait_idle(n);
        chk_mem("R4 offset 62", 11'h27E, 8'hC0);
        chk_mem("R4 offset 63", 11'h27F, 8'hC1);
        chk_mem("R4 wrapped offset 0", 11'h240, 8'hC2);
        chk_mem("R4 wrapped offset 1", 11'h241, 8'hC3);
        chk_mem("R4 next page untouched", 11'h280, 8'h00);
        chk_mem("R4 next page untouched", 11'h281, 8'h00);
        chk("R4 pointer stays in page", {21'h0, addr_ptr}, 32'h242);
    endtask

    task automatic t_overflow();
        int n;
        send_cmd(11'h300);
        for (int i = 0; i < 66; i++) send_byte(8'(i * 3 + 1));
        send_stop(); wait_idle(n);
        chk_mem("R5 slot 0 overwritten", 11'h300, 8'(64 * 3 + 1));
        chk_mem("R5 slot 1 overwritten", 11'h301, 8'(65 * 3 + 1));
        chk_mem("R5 slot 2 kept", 11'h302, 8'(2 * 3 + 1));
        chk_mem("R5 slot 63 kept", 11'h33F, 8'(63 * 3 + 1));
    endtask

    task automatic t_refresh();
        int n;
        send_cmd(11'h202); send_byte(8'hEE); send_stop(); wait_idle(n);
        chk_mem("R6 rewritten byte", 11'h202, 8'hEE);
        chk_mem("R6 refreshed byte", 11'h200, 8'h10);
        chk_mem("R6 refreshed byte", 11'h201, 8'h11);
        chk_mem("R6 refreshed byte", 11'h203, 8'h13);
        chk_mem("R6 refreshed byte", 11'h204, 8'h14);
    endtask

    task automatic t_wp_stop();
        int n;
        send_cmd(11'h400); send_byte(8'h11); wp = 1'b1; send_stop();
        wp = 1'b0;
        chk("R7 no busy when protected", {31'h0, busy}, 0);
        start_addr = 11'h401; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        chk("R7 no busy later", {31'h0, busy}, 0);
        send_byte(8'h22); send_stop();
        chk("R7 next command commits", {31'h0, busy}, 1);
        wait_idle(n);
        chk_mem("R7 protected byte absent", 11'h400, 8'h00);
        chk_mem("R7 next command stored", 11'h401, 8'h22);
    endtask

    task automatic t_wp_timing();
        int n;
        wp = 1'b1;
        send_cmd(11'h440); send_byte(8'h5A);
        wp = 1'b0; send_stop();
        wp = 1'b1;
        chk("R8 commit despite later wp", {31'h0, busy}, 1);
        wait_idle(n);
        wp = 1'b0;
        chk_mem("R8 byte stored", 11'h440, 8'h5A);
    endtask

    task automatic t_busy_ignore();
        int n;
        send_cmd(11'h480); send_byte(8'h66); send_stop();
        send_cmd(11'h500); send_byte(8'h77); send_stop();
        chk("R10 pointer frozen while busy", {21'h0, addr_ptr}, 32'h481);
        wait_idle(n);
        chk("R10 idle after single commit", {31'h0, busy}, 0);
        chk("R10 pointer unchanged", {21'h0, addr_ptr}, 32'h481);
        chk_mem("R10 ignored byte absent", 11'h500, 8'h00);
        chk_mem("R10 first byte stored", 11'h480, 8'h66);
    endtask

    task automatic t_empty_cmd();
        send_cmd(11'h123); send_stop();
        chk("R11 no busy without data", {31'h0, busy}, 0);
        chk("R11 pointer holds start", {21'h0, addr_ptr}, 32'h123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_write();
        t_page_write();
        t_wrap();
        t_overflow();
        t_refresh();
        t_wp_stop();
        t_wp_timing();
        t_busy_ignore();
        t_empty_cmd();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule